// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Aggregator

This block watches up to 128 general-purpose pins, grouped in banks of 32. Each pin's level passes through a two-flop synchronizer. The block then compares the synchronized level with the level from the cycle before. A rising or falling transition on a pin configured as an input sets that pin's sticky status bit, provided the matching per-pin enable is on. Software clears status bits by presenting a mask of ones with a clear strobe. Bits that see a new edge in the same cycle stay set.

The status vector is reduced to three interrupt lines. Pin 0 and pin 1 each drive a dedicated line, and every other pin shares the third. A separate wake request pulses for one cycle when a wake-capable input pin changes level while the processor reports that it is halted. A fixed mask per bank decides which pins are wake-capable. A parameter sets how many pins are implemented. Pins above that count never report anything.

Direction, enable and clear inputs are plain level controls with no handshake. The block accepts a clear strobe in every cycle. Register decoding belongs to the surrounding logic.

Top module: `gpio_edge_irq`

## Requirements
- R1: A low-to-high change on a pin whose direction bit is 0 (input) and whose rising-enable bit is 1 sets its status bit. A level applied before clock edge n is visible in `status` after edge n+2, and not after edge n+1.
- R2: A high-to-low change on an input pin whose falling-enable bit is 1 sets its status bit, with the same latency as R1.
- R3: A pin whose direction bit is 1 (output) never sets its status bit. A transition whose matching enable bit is 0 is ignored.
- R4: Status bits are sticky. When `clr_we` is high at a clock edge, every bit with a 1 in `clr_mask` is cleared at that edge. Bits with 0 in the mask keep their value.
- R5: When a new edge and a clear hit the same bit at the same clock edge, the bit ends up set.
- R6: `irq_pin0` equals status bit 0 and `irq_pin1` equals status bit 1, combinationally.
- R7: `irq_rest` is the OR of status bits 2 through 127.
- R8: `wake_req` is a one-cycle pulse that appears at the same edge at which a status bit would set. It fires when an implemented input pin in the wake mask changes level in either direction while `halted` is high, whatever its edge enables are. Wake masks are 0x8003FE1B for pins 31..0, 0x002001FC for pins 63..32, 0xEC080000 for pins 95..64 and 0x0012007F for pins 127..96.
- R9: Status bits at index NUM_PINS and above are always 0, and those pins cause no wake request.
- R10: While reset is asserted and just after it, `status` is zero and all three interrupt lines and `wake_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_level | input | 128 | Raw pin levels, asynchronous |
| dir_mask | input | 128 | 1 = pin is an output, 0 = input |
| rise_en | input | 128 | Per-pin rising-edge enable |
| fall_en | input | 128 | Per-pin falling-edge enable |
| clr_we | input | 1 | Clear strobe for status bits |
| clr_mask | input | 128 | Ones select status bits to clear |
| halted | input | 1 | Processor halted flag |
| status | output | 128 | Sticky edge status bits |
| irq_pin0 | output | 1 | Interrupt for pin 0 |
| irq_pin1 | output | 1 | Interrupt for pin 1 |
| irq_rest | output | 1 | Shared interrupt for pins 2 and up |
| wake_req | output | 1 | One-cycle wake pulse |

## Verification
The edge detector is driven with rising changes under rising enable, and with falling changes while only falling enable is on. This separates the two polarities, and a rise with rising enable off shows that an enable really gates its polarity. The same toggles on an output-configured pin show that direction masks detection. A clear that lands in the same cycle as a fresh edge separates edge priority from plain clearing. Wake tests toggle a non-wake pin, a wake pin while running, a wake pin configured as an output, and wake pins in two banks in both directions. A second instance with 40 pins checks that high pins stay silent.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned BANK_W    = 32;
  localparam int unsigned MAX_BANKS = 4;
  localparam int unsigned MAX_PINS  = BANK_W * MAX_BANKS;

  typedef logic [BANK_W-1:0]   bank_t;
  typedef logic [MAX_PINS-1:0] pinvec_t;

  // Fixed wake-capable pins per bank.
  function automatic bank_t wake_bank_mask(input int b);
    case (b)
      0:       wake_bank_mask = 32'h8003_FE1B;
      1:       wake_bank_mask = 32'h0020_01FC;
      2:       wake_bank_mask = 32'hEC08_0000;
      3:       wake_bank_mask = 32'h0012_007F;
      default: wake_bank_mask = '0;
    endcase
  endfunction

  // Ones for implemented pins.
  function automatic pinvec_t impl_vec(input int n);
    pinvec_t v;
    for (int i = 0; i < int'(MAX_PINS); i++) v[i] = (i < n);
    impl_vec = v;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= async_in;
      stage2 <= stage1;
    end
  end

  assign sync_out = stage2;
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter bank_t IMPL_MASK = '1,
  parameter bank_t WAKE_MASK = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  bank_t lvl_now,
  input  bank_t dir,
  input  bank_t rise,
  input  bank_t fall,
  input  logic  clr_we,
  input  bank_t clr,
  input  logic  halted,
  output bank_t status,
  output logic  wake_hit
);
  bank_t lvl_prev;
  bank_t in_mask;
  bank_t set_bits;
  bank_t clr_bits;
  bank_t status_q;

  always_comb begin
    in_mask  = ~dir & IMPL_MASK;
    set_bits = ((lvl_now & ~lvl_prev & rise) | (~lvl_now & lvl_prev & fall)) & in_mask;
    clr_bits = clr_we ? clr : '0;
    wake_hit = halted & (|((lvl_now ^ lvl_prev) & in_mask & WAKE_MASK));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev <= '0;
      status_q <= '0;
    end else begin
      lvl_prev <= lvl_now;
      // a fresh edge overrides a clear of the same bit
      status_q <= ((status_q & ~clr_bits) | set_bits) & IMPL_MASK;
    end
  end

  assign status = status_q;
endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine
  import gpio_edge_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  pinvec_t              status,
  input  logic [MAX_BANKS-1:0] wake_hits,
  output logic                 irq_pin0,
  output logic                 irq_pin1,
  output logic                 irq_rest,
  output logic                 wake_req
);
  logic wake_q;

  assign irq_pin0 = status[0];
  assign irq_pin1 = status[1];
  assign irq_rest = |status[MAX_PINS-1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= |wake_hits;
  end

  assign wake_req = wake_q;
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NUM_PINS = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [127:0] pin_level,
  input  logic [127:0] dir_mask,
  input  logic [127:0] rise_en,
  input  logic [127:0] fall_en,
  input  logic         clr_we,
  input  logic [127:0] clr_mask,
  input  logic         halted,
  output logic [127:0] status,
  output logic         irq_pin0,
  output logic         irq_pin1,
  output logic         irq_rest,
  output logic         wake_req
);
  localparam pinvec_t IMPL = impl_vec(int'(NUM_PINS));

  pinvec_t              lvl_sync;
  pinvec_t              status_all;
  logic [MAX_BANKS-1:0] wake_hits;

  gpio_sync #(.W(MAX_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_level),
    .sync_out (lvl_sync)
  );

  for (genvar b = 0; b < int'(MAX_BANKS); b++) begin : g_bank
    gpio_edge_bank #(
      .IMPL_MASK (IMPL[b*BANK_W +: BANK_W]),
      .WAKE_MASK (wake_bank_mask(b))
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_now  (lvl_sync[b*BANK_W +: BANK_W]),
      .dir      (dir_mask[b*BANK_W +: BANK_W]),
      .rise     (rise_en[b*BANK_W +: BANK_W]),
      .fall     (fall_en[b*BANK_W +: BANK_W]),
      .clr_we   (clr_we),
      .clr      (clr_mask[b*BANK_W +: BANK_W]),
      .halted   (halted),
      .status   (status_all[b*BANK_W +: BANK_W]),
      .wake_hit (wake_hits[b])
    );
  end

  gpio_irq_combine u_comb (
    .clk       (clk),
    .rst_n     (rst_n),
    .status    (status_all),
    .wake_hits (wake_hits),
    .irq_pin0  (irq_pin0),
    .irq_pin1  (irq_pin1),
    .irq_rest  (irq_rest),
    .wake_req  (wake_req)
  );

  assign status = status_all;
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NUM_PINS = 128
) (
  input logic         clk,
  input logic         rst_n,
  input logic [127:0] dir_mask,
  input logic         clr_we,
  input logic         halted,
  input logic [127:0] status,
  input logic         irq_pin0,
  input logic         irq_pin1,
  input logic         irq_rest,
  input logic         wake_req
);
  localparam pinvec_t IMPL = impl_vec(int'(NUM_PINS));

  // R4: without a clear strobe no bit drops
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((status & $past(status)) == $past(status)));

  // R3: newly set bits were inputs in the detecting cycle
  p_out_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & $past(dir_mask)) == '0));

  // R6: dedicated lines follow bits 0 and 1
  p_irq_ab_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pin0 == status[0]) && (irq_pin1 == status[1]));

  // R7: shared line follows the rest
  p_irq_rest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rest == (|status[127:2]));

  // R8: wake only follows a halted cycle
  p_wake_halted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(halted));

  // R9: unimplemented pins stay zero
  p_unimpl_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~IMPL) == '0);
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dir_mask (dir_mask),
  .clr_we   (clr_we),
  .halted   (halted),
  .status   (status),
  .irq_pin0 (irq_pin0),
  .irq_pin1 (irq_pin1),
  .irq_rest (irq_rest),
  .wake_req (wake_req)
);

// File: tb/tb_gpio_edge_irq.sv
`timescale 1ns/1ps
module tb_gpio_edge_irq;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] pin_level = '0;
  logic [127:0] dir_mask = '0;
  logic [127:0] rise_en = '0;
  logic [127:0] fall_en = '0;
  logic         clr_we = 1'b0;
  logic [127:0] clr_mask = '0;
  logic         halted = 1'b0;
  logic [127:0] status, status_s;
  logic         irq_pin0, irq_pin1, irq_rest, wake_req;
  logic         irq0_s, irq1_s, irqr_s, wake_s;

  logic [127:0] exp_st = '0;
  int nchecks = 0;
  int nerrors = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  gpio_edge_irq dut (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .dir_mask(dir_mask),
    .rise_en(rise_en), .fall_en(fall_en), .clr_we(clr_we), .clr_mask(clr_mask),
    .halted(halted), .status(status), .irq_pin0(irq_pin0), .irq_pin1(irq_pin1),
    .irq_rest(irq_rest), .wake_req(wake_req)
  );

  gpio_edge_irq #(.NUM_PINS(40)) dut_n40 (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .dir_mask(dir_mask),
    .rise_en(rise_en), .fall_en(fall_en), .clr_we(clr_we), .clr_mask(clr_mask),
    .halted(halted), .status(status_s), .irq_pin0(irq0_s), .irq_pin1(irq1_s),
    .irq_rest(irqr_s), .wake_req(wake_s)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] expv);
    nchecks++;
    if (act !== expv) begin
      nerrors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one pin and capture wake_req at the next four falling edges
  task automatic drive_pin(input int p, input logic v, output logic [3:0] wk);
    pin_level[p] = v;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      wk[i] = wake_req;
    end
  endtask

  task automatic t_reset;
    chk("R10 status in reset", status, '0);
    chk("R10 irqs in reset", {125'd0, irq_pin0, irq_pin1, irq_rest}, '0);
    rst_n = 1'b1;
    wait_n(2);
    chk("R10 status after reset", status, '0);
    chk("R10 wake after reset", {127'd0, wake_req}, '0);
  endtask

  task automatic t_rise;
    rise_en = '1;
    pin_level[0] = 1'b1;
    wait_n(2);
    chk("R1 not yet after edge n+1", status, exp_st);
    wait_n(1);
    exp_st[0] = 1'b1;
    chk("R1 rise pin0", status, exp_st);
    chk("R6 irq lines pin0", {125'd0, irq_pin0, irq_pin1, irq_rest}, 128'b100);
    pin_level[100] = 1'b1;
    wait_n(3);
    exp_st[100] = 1'b1;
    chk("R1 rise pin100", status, exp_st);
    chk("R7 shared irq", {127'd0, irq_rest}, 128'd1);
  endtask

  task automatic t_fall;
    rise_en = '0;
    fall_en = '0;
    fall_en[1] = 1'b1;
    pin_level[1] = 1'b1;
    wait_n(3);
    chk("R3 rise with enable off", status, exp_st);
    pin_level[1] = 1'b0;
    wait_n(3);
    exp_st[1] = 1'b1;
    chk("R2 fall pin1", status, exp_st);
    chk("R6 irq pin1", {127'd0, irq_pin1}, 128'd1);
  endtask

  task automatic t_ignore;
    rise_en = '1;
    fall_en = '1;
    dir_mask[7] = 1'b1;
    pin_level[7] = 1'b1;
    wait_n(3);
    chk("R3 output rise ignored", status, exp_st);
    pin_level[7] = 1'b0;
    wait_n(3);
    chk("R3 output fall ignored", status, exp_st);
    rise_en = '0;
    fall_en = '0;
  endtask

  task automatic t_clear;
    clr_mask = '0;
    clr_mask[0] = 1'b1;
    clr_mask[3] = 1'b1;
    clr_we = 1'b1;
    wait_n(1);
    clr_we = 1'b0;
    exp_st[0] = 1'b0;
    chk("R4 clear bit0 only", status, exp_st);
    chk("R6 irq pin0 dropped", {127'd0, irq_pin0}, 128'd0);
    clr_mask = '1;
    clr_we = 1'b1;
    wait_n(1);
    clr_we = 1'b0;
    exp_st = '0;
    chk("R4 clear all", status, exp_st);
    chk("R7 irqs low after clear", {125'd0, irq_pin0, irq_pin1, irq_rest}, '0);
  endtask

  task automatic t_edge_wins;
    rise_en = '1;
    pin_level[40] = 1'b1;
    wait_n(3);
    exp_st[40] = 1'b1;
    pin_level[20] = 1'b1;
    wait_n(2);
    clr_mask = '0;
    clr_mask[20] = 1'b1;
    clr_mask[40] = 1'b1;
    clr_we = 1'b1;
    wait_n(1);
    clr_we = 1'b0;
    exp_st[40] = 1'b0;
    exp_st[20] = 1'b1;
    chk("R5 edge beats clear", status, exp_st);
    rise_en = '0;
  endtask

  task automatic t_wake;
    logic [3:0] wk;
    halted = 1'b1;
    drive_pin(2, 1'b1, wk);
    chk("R8 non-wake pin", {124'd0, wk}, 128'b0000);
    drive_pin(3, 1'b1, wk);
    chk("R8 wake pin rise", {124'd0, wk}, 128'b0100);
    drive_pin(3, 1'b0, wk);
    chk("R8 wake pin fall", {124'd0, wk}, 128'b0100);
    halted = 1'b0;
    drive_pin(3, 1'b1, wk);
    chk("R8 not halted", {124'd0, wk}, 128'b0000);
    halted = 1'b1;
    dir_mask[3] = 1'b1;
    drive_pin(3, 1'b0, wk);
    chk("R8 output pin", {124'd0, wk}, 128'b0000);
    dir_mask[3] = 1'b0;
    drive_pin(34, 1'b1, wk);
    chk("R8 bank1 wake pin", {124'd0, wk}, 128'b0100);
    drive_pin(83, 1'b1, wk);
    chk("R8 bank2 wake pin", {124'd0, wk}, 128'b0100);
    chk("R8 status untouched", status, exp_st);
    halted = 1'b0;
  endtask

  task automatic t_unimpl;
    logic [3:0] wk;
    rise_en = '1;
    pin_level[45] = 1'b1;
    wait_n(3);
    exp_st[45] = 1'b1;
    chk("R9 full instance pin45", status, exp_st);
    chk("R9 small instance high bits", {88'd0, status_s[127:40]}, '0);
    chk("R9 small instance low bits", {88'd0, status_s[39:0]}, {88'd0, exp_st[39:0]});
    rise_en = '0;
    halted = 1'b1;
    pin_level[96] = 1'b1;
    wk = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      wk[i] = wake_s;
    end
    chk("R9 small instance no wake", {124'd0, wk}, '0);
    halted = 1'b0;
  endtask

  initial begin
    wait_n(3);
    t_reset();
    t_rise();
    t_fall();
    t_ignore();
    t_clear();
    t_edge_wins();
    t_wake();
    t_unimpl();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nchecks++;
        nerrors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end
endmodule